// File: doc/BRIEF.md
# DMA and Interrupt Request Handshake

This block sits between a peripheral's data FIFO and the host bus. It raises a single-channel byte DMA request when the FIFO says a transfer is needed. It watches the host's acknowledge and the read and write strobes, and it hands a one-cycle byte strobe to the data path each time a byte moves. The request, the acknowledge and the interrupt line each have an active level chosen by a configuration bit, so the block can connect to hosts with either signalling convention.

When the host DMA controller signals terminal count during an acknowledged transfer, the block emits a one-cycle end-of-block pulse. It then holds the request inactive until software re-arms the channel. The interrupt output follows the pending flag from the interrupt sources with no delay. A register-access enable tells the host decoder when a chip-select access is a register cycle rather than a DMA cycle.

All inputs are taken as synchronous to `clk`.

Top module: `dma_irq_handshake`

## Requirements
- R1: `drq_pin` is at its inactive level after reset. Its active level is high when `cfg_drq_hi`=1 and low when `cfg_drq_hi`=0, and a change of this bit takes effect at once.
- R2: When `xfer_need` is 1 and the channel is not blocked, the request is active on the clock after `xfer_need` is seen.
- R3: Acknowledge is active when `dack_pin` equals `cfg_dack_hi`. A completed strobe is recognised only if acknowledge was active while the strobe was low.
- R4: A transfer completes on the first clock at which a read strobe (`ior_n` low) or a write strobe (`iow_n` low) has returned high. `byte_stb` is 1 for exactly the cycle after that clock.
- R5: The request goes inactive on the same clock at which `byte_stb` rises. It stays inactive while `byte_stb` is 1, and it can return no earlier than the following clock.
- R6: If `tc` was 1 with acknowledge active during the strobe, `eob` pulses for one cycle together with `byte_stb`. After that, the request stays inactive while `xfer_need` is 1.
- R7: `tc` has no effect while acknowledge is inactive: no `eob`, no byte strobe, and no blocking.
- R8: A one-cycle `rearm` pulse clears the block, and the request returns two clocks after `rearm` is driven.
- R9: `irq_pin` shows `irq_pending` combinationally, at the level chosen by `cfg_irq_hi` (1 means active high).
- R10: `reg_access_en` is 1 only when `cs_n` is 0 and `aen` is 0. Register decoding is suppressed during DMA cycles.
- R11: A strobe without acknowledge produces no `byte_stb` and leaves an active request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_drq_hi | input | 1 | Request active level (1 means high) |
| cfg_dack_hi | input | 1 | Acknowledge active level (1 means high) |
| cfg_irq_hi | input | 1 | Interrupt active level (1 means high) |
| xfer_need | input | 1 | FIFO requests a byte transfer |
| irq_pending | input | 1 | An enabled interrupt source is pending |
| rearm | input | 1 | Software re-arm after end of block |
| cs_n | input | 1 | Chip select, active low |
| aen | input | 1 | Address enable, high during DMA |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| dack_pin | input | 1 | DMA acknowledge pin |
| tc | input | 1 | Terminal count |
| drq_pin | output | 1 | DMA request pin |
| irq_pin | output | 1 | Interrupt request pin |
| byte_stb | output | 1 | One-cycle per-byte transfer strobe |
| eob | output | 1 | One-cycle end-of-block pulse |
| reg_access_en | output | 1 | Register access permitted |

## Verification
A wrong internal state shows up within one or two clocks of a strobe's trailing edge. A stale strobe or acknowledge register gives a missing or doubled `byte_stb`. A request that fails to drop gives a duplicate transfer. A block flag that is lost, or never cleared, shows as `drq_pin` staying wrong while `xfer_need` is held at 1. The polarity bits are checked by flipping each one and reading the pin in the same cycle.

// File: rtl/dma_irq_handshake.sv
module dma_irq_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_drq_hi,
  input  logic cfg_dack_hi,
  input  logic cfg_irq_hi,
  input  logic xfer_need,
  input  logic irq_pending,
  input  logic rearm,
  input  logic cs_n,
  input  logic aen,
  input  logic ior_n,
  input  logic iow_n,
  input  logic dack_pin,
  input  logic tc,
  output logic drq_pin,
  output logic irq_pin,
  output logic byte_stb,
  output logic eob,
  output logic reg_access_en
);

  logic dack_act, strobe, done;
  logic strb_q, dack_q, tc_q, drq_q, blocked;

  assign dack_act = (dack_pin == cfg_dack_hi);
  assign strobe   = ~ior_n | ~iow_n;
  assign done     = strb_q & ~strobe & dack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      dack_q   <= 1'b0;
      tc_q     <= 1'b0;
      byte_stb <= 1'b0;
      eob      <= 1'b0;
      blocked  <= 1'b0;
      drq_q    <= 1'b0;
    end else begin
      strb_q   <= strobe;
      dack_q   <= strobe ? dack_act : 1'b0;
      tc_q     <= strobe ? (tc & dack_act) : 1'b0;
      byte_stb <= done;
      eob      <= done & tc_q;
      if (done & tc_q)  blocked <= 1'b1;
      else if (rearm)   blocked <= 1'b0;
      drq_q    <= xfer_need & ~blocked & ~done & ~byte_stb;
    end
  end

  assign drq_pin       = cfg_drq_hi ? drq_q : ~drq_q;
  assign irq_pin       = cfg_irq_hi ? irq_pending : ~irq_pending;
  assign reg_access_en = ~cs_n & ~aen;

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb); // R4
  AST_DRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> !drq_q); // R5
  AST_EOB_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    eob |-> byte_stb); // R6
  AST_BLOCK_AFTER_EOB: assert property (@(posedge clk) disable iff (!rst_n)
    eob |=> !drq_q); // R6
  AST_STB_NEEDS_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(dack_act, 2)); // R3
  AST_NO_REG_IN_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> !reg_access_en); // R10

endmodule

// File: tb/dma_irq_handshake_tb.sv
module dma_irq_handshake_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_drq_hi = 1, cfg_dack_hi = 0, cfg_irq_hi = 1;
  logic xfer_need = 0, irq_pending = 0, rearm = 0, cs_n = 1, aen = 0;
  logic ior_n = 1, iow_n = 1, dack_pin = 1, tc = 0;
  logic drq_pin, irq_pin, byte_stb, eob, reg_access_en;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_irq_handshake u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_drq_hi(cfg_drq_hi), .cfg_dack_hi(cfg_dack_hi),
    .cfg_irq_hi(cfg_irq_hi), .xfer_need(xfer_need), .irq_pending(irq_pending),
    .rearm(rearm), .cs_n(cs_n), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
    .dack_pin(dack_pin), .tc(tc), .drq_pin(drq_pin), .irq_pin(irq_pin),
    .byte_stb(byte_stb), .eob(eob), .reg_access_en(reg_access_en));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse(input logic is_read);
    @(negedge clk);
    if (is_read) ior_n = 0; else iow_n = 0;
    @(negedge clk);
    ior_n = 1; iow_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 drq reset", drq_pin, 1'b0);
    chk("R4 stb reset", byte_stb, 1'b0);
    chk("R6 eob reset", eob, 1'b0);
    chk("R9 irq reset", irq_pin, 1'b0);
  endtask

  task automatic t_request;
    xfer_need = 1;
    @(negedge clk);
    chk("R2 drq asserted", drq_pin, 1'b1);
    cfg_drq_hi = 0; #1;
    chk("R1 drq active low", drq_pin, 1'b0);
    cfg_drq_hi = 1; #1;
    chk("R1 drq active high", drq_pin, 1'b1);
  endtask

  task automatic t_xfer(input logic is_read);
    dack_pin = 0; aen = 1; cs_n = 0;
    pulse(is_read);
    chk("R4 byte_stb", byte_stb, 1'b1);
    chk("R5 drq dropped", drq_pin, 1'b0);
    chk("R6 no eob", eob, 1'b0);
    chk("R10 no reg access in dma", reg_access_en, 1'b0);
    @(negedge clk);
    chk("R4 stb one cycle", byte_stb, 1'b0);
    chk("R5 drq still low", drq_pin, 1'b0);
    @(negedge clk);
    chk("R2 drq returns", drq_pin, 1'b1);
    dack_pin = 1; aen = 0; cs_n = 1;
  endtask

  task automatic t_no_dack;
    pulse(1);
    chk("R11 no stb", byte_stb, 1'b0);
    chk("R11 drq kept", drq_pin, 1'b1);
    @(negedge clk);
    chk("R11 no stb later", byte_stb, 1'b0);
    cfg_dack_hi = 1; dack_pin = 1;
    pulse(0);
    chk("R3 high-active dack", byte_stb, 1'b1);
    cfg_dack_hi = 0; dack_pin = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_tc_ignored;
    tc = 1;
    pulse(1);
    chk("R7 no eob", eob, 1'b0);
    chk("R7 no stb", byte_stb, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7 not blocked", drq_pin, 1'b1);
    tc = 0;
  endtask

  task automatic t_tc;
    dack_pin = 0; tc = 1;
    pulse(0);
    chk("R6 eob", eob, 1'b1);
    chk("R6 stb with eob", byte_stb, 1'b1);
    dack_pin = 1; tc = 0;
    @(negedge clk);
    chk("R6 eob one cycle", eob, 1'b0);
    repeat (4) @(negedge clk);
    chk("R6 blocked", drq_pin, 1'b0);
    rearm = 1;
    @(negedge clk);
    rearm = 0;
    @(negedge clk);
    chk("R8 rearmed", drq_pin, 1'b1);
  endtask

  task automatic t_irq;
    irq_pending = 1; #1;
    chk("R9 irq high", irq_pin, 1'b1);
    cfg_irq_hi = 0; #1;
    chk("R9 irq low-active", irq_pin, 1'b0);
    irq_pending = 0; #1;
    chk("R9 irq cleared", irq_pin, 1'b1);
    cfg_irq_hi = 1;
  endtask

  task automatic t_access;
    cs_n = 0; aen = 0; #1;
    chk("R10 access", reg_access_en, 1'b1);
    aen = 1; #1;
    chk("R10 dma blocks", reg_access_en, 1'b0);
    cs_n = 1; aen = 0; #1;
    chk("R10 no cs", reg_access_en, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_request();
    t_xfer(1);
    t_xfer(0);
    t_no_dack();
    t_tc_ignored();
    t_tc();
    t_irq();
    t_access();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule